// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns one routing request into a sequence of per-CPU interrupt injections. A request carries an 8-bit destination, a flag that chooses between physical and logical addressing, a 3-bit delivery mode, an 8-bit vector and a trigger-mode bit. The resolver compares the destination with per-CPU tables of physical IDs, logical IDs, present flags and arbitration priorities, and builds a target set from them. It then issues injections of (CPU index, vector, trigger) over a valid/ready stream.

In fixed mode, every CPU in the target set receives one beat, lowest index first. In lowest-priority mode, a single CPU is picked from the set. Any other mode code is rejected with an unsupported pulse and produces no beat. Each request finishes with a one-cycle done pulse. The block accepts a new request only when it is idle.

Top module: `intr_dest_resolver`

## Requirements
- R1: In physical mode (`req_logical`=0), destination 0xFF targets every CPU whose present bit is set.
- R2: In physical mode with any destination other than 0xFF, only the lowest-index present CPU whose physical ID equals the destination is targeted.
- R3: In logical mode (`req_logical`=1), destination 0 targets no CPU. Otherwise, every present CPU whose 8-bit logical ID shares at least one set bit with the destination is targeted.
- R4: When the target set is empty, no beat is issued, and `done` pulses in the cycle after the request is accepted.
- R5: Mode code 0 (fixed) issues one beat per targeted CPU in ascending index order. Every beat carries the request's vector and trigger bit.
- R6: Mode code 1 (lowest priority) issues exactly one beat. It goes to the targeted CPU with the smallest priority value, and a tie goes to the lowest index.
- R7: Mode codes 2 through 7 issue no beat. `unsupported` and `done` pulse together in the cycle after acceptance.
- R8: `inj_valid` stays high with a stable payload until `inj_ready` is sampled high. `req_ready` is low while beats are pending.
- R9: `done` pulses for exactly one cycle, in the cycle after the last beat is accepted.
- R10: After reset, `req_ready` is 1 and `inj_valid`, `done` and `unsupported` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Resolver idle and able to accept |
| req_dest | input | 8 | Destination ID |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_mode | input | 3 | Delivery mode code |
| req_vec | input | 8 | Interrupt vector |
| req_level | input | 1 | Trigger mode (1 level, 0 edge) |
| cpu_present | input | NUM_CPU | Per-CPU present flags |
| cpu_phys_id | input | NUM_CPU*8 | Physical IDs, CPU i at bits [8i+7:8i] |
| cpu_log_id | input | NUM_CPU*8 | Logical IDs, CPU i at bits [8i+7:8i] |
| cpu_prio | input | NUM_CPU*PRIO_W | Arbitration priorities, lower wins |
| inj_valid | output | 1 | Injection beat valid |
| inj_ready | input | 1 | Injection beat accepted |
| inj_cpu | output | IDX_W | Target CPU index |
| inj_vector | output | 8 | Vector of the beat |
| inj_level | output | 1 | Trigger mode of the beat |
| done | output | 1 | One-cycle end-of-request pulse |
| unsupported | output | 1 | One-cycle rejected-mode pulse |

## Verification
A request is accepted on a rising edge. The first beat is visible in the next cycle, and so is `done`/`unsupported` when there is nothing to send. With `inj_ready` held high, beat k appears k cycles later. `done` follows one cycle after the last beat, and each stall cycle moves every later event back by one. The bench counts cycles from the acceptance edge, samples on the falling edge, and compares the cycle in which `done` arrives with the beat count plus the stall count it applied.

// File: rtl/idr_pkg.sv
package idr_pkg;
    localparam int ID_W  = 8;
    localparam int VEC_W = 8;

    localparam logic [2:0] MODE_FIXED  = 3'd0;
    localparam logic [2:0] MODE_LOWEST = 3'd1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } idr_state_e;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        logic             level;
    } idr_job_t;
endpackage

// File: rtl/idr_target_mask.sv
module idr_target_mask
    import idr_pkg::*;
#(
    parameter int NUM_CPU = 8
) (
    input  logic [ID_W-1:0]         dest,
    input  logic                    logical,
    input  logic [NUM_CPU-1:0]      present,
    input  logic [NUM_CPU*ID_W-1:0] phys_flat,
    input  logic [NUM_CPU*ID_W-1:0] log_flat,
    output logic [NUM_CPU-1:0]      tgt_mask
);
    localparam logic [ID_W-1:0] BCAST = '1;

    logic [NUM_CPU-1:0] phys_hit;
    logic [NUM_CPU-1:0] log_hit;
    logic [NUM_CPU-1:0] first_hit;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cmp
        assign phys_hit[g] = present[g] && (phys_flat[g*ID_W +: ID_W] == dest);
        assign log_hit[g]  = present[g] && (|(log_flat[g*ID_W +: ID_W] & dest));
    end

    always_comb begin
        logic found;
        found     = 1'b0;
        first_hit = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (phys_hit[i] && !found) begin
                first_hit[i] = 1'b1;
                found        = 1'b1;
            end
        end
    end

    always_comb begin
        if (logical)
            tgt_mask = (dest == '0) ? '0 : log_hit;
        else if (dest == BCAST)
            tgt_mask = present;
        else
            tgt_mask = first_hit;
    end
endmodule

// File: rtl/idr_prio_pick.sv
module idr_prio_pick #(
    parameter int NUM_CPU = 8,
    parameter int PRIO_W  = 8
) (
    input  logic [NUM_CPU-1:0]        cand,
    input  logic [NUM_CPU*PRIO_W-1:0] prio_flat,
    output logic [NUM_CPU-1:0]        win_onehot
);
    always_comb begin
        logic              found;
        logic [PRIO_W-1:0] best;
        found      = 1'b0;
        best       = '0;
        win_onehot = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (cand[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < best)) begin
                found      = 1'b1;
                best       = prio_flat[i*PRIO_W +: PRIO_W];
                win_onehot = '0;
                win_onehot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intr_dest_resolver.sv
module intr_dest_resolver
    import idr_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ID_W-1:0]           req_dest,
    input  logic                      req_logical,
    input  logic [2:0]                req_mode,
    input  logic [VEC_W-1:0]          req_vec,
    input  logic                      req_level,
    input  logic [NUM_CPU-1:0]        cpu_present,
    input  logic [NUM_CPU*ID_W-1:0]   cpu_phys_id,
    input  logic [NUM_CPU*ID_W-1:0]   cpu_log_id,
    input  logic [NUM_CPU*PRIO_W-1:0] cpu_prio,
    output logic                      inj_valid,
    input  logic                      inj_ready,
    output logic [IDX_W-1:0]          inj_cpu,
    output logic [VEC_W-1:0]          inj_vector,
    output logic                      inj_level,
    output logic                      done,
    output logic                      unsupported
);
    idr_state_e         state_q;
    idr_job_t           job_q;
    logic [NUM_CPU-1:0] pend_q;
    logic               done_q;
    logic               unsup_q;

    logic [NUM_CPU-1:0] tgt_mask;
    logic [NUM_CPU-1:0] win_onehot;
    logic [NUM_CPU-1:0] sel_mask;
    logic [NUM_CPU-1:0] cur_onehot;
    logic [NUM_CPU-1:0] pend_next;
    logic [IDX_W-1:0]   cur_idx;
    logic               accept;
    logic               is_fixed;
    logic               is_lowest;

    idr_target_mask #(.NUM_CPU(NUM_CPU)) mask_i (
        .dest      (req_dest),
        .logical   (req_logical),
        .present   (cpu_present),
        .phys_flat (cpu_phys_id),
        .log_flat  (cpu_log_id),
        .tgt_mask  (tgt_mask)
    );

    idr_prio_pick #(.NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)) pick_i (
        .cand       (tgt_mask),
        .prio_flat  (cpu_prio),
        .win_onehot (win_onehot)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign is_fixed  = (req_mode == MODE_FIXED);
    assign is_lowest = (req_mode == MODE_LOWEST);
    assign sel_mask  = is_lowest ? win_onehot : tgt_mask;

    always_comb begin
        logic found;
        found      = 1'b0;
        cur_idx    = '0;
        cur_onehot = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (pend_q[i] && !found) begin
                found         = 1'b1;
                cur_idx       = IDX_W'(i);
                cur_onehot[i] = 1'b1;
            end
        end
    end

    assign pend_next = pend_q & ~cur_onehot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            job_q   <= '0;
            pend_q  <= '0;
            done_q  <= 1'b0;
            unsup_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            unsup_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        job_q.vector <= req_vec;
                        job_q.level  <= req_level;
                        if (!is_fixed && !is_lowest) begin
                            unsup_q <= 1'b1;
                            done_q  <= 1'b1;
                        end else if (sel_mask == '0) begin
                            done_q  <= 1'b1;
                        end else begin
                            pend_q  <= sel_mask;
                            state_q <= ST_SEND;
                        end
                    end
                end
                ST_SEND: begin
                    if (inj_ready) begin
                        pend_q <= pend_next;
                        if (pend_next == '0) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign inj_valid   = (state_q == ST_SEND);
    assign inj_cpu     = cur_idx;
    assign inj_vector  = job_q.vector;
    assign inj_level   = job_q.level;
    assign done        = done_q;
    assign unsupported = unsup_q;
endmodule

// File: rtl/idr_checker.sv
module idr_checker #(
    parameter int NUM_CPU = 8,
    localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             inj_valid,
    input logic             inj_ready,
    input logic [IDX_W-1:0] inj_cpu,
    input logic [7:0]       inj_vector,
    input logic             inj_level,
    input logic             done,
    input logic             unsupported
);
    // R8
    hold_payload_chk: assert property (@(posedge clk) disable iff (rst)
        inj_valid && !inj_ready |=> inj_valid && $stable(inj_cpu)
                                    && $stable(inj_vector) && $stable(inj_level));

    // R8
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        inj_valid |-> !req_ready);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    unsup_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> done && !inj_valid);

    // R5
    ascending_chk: assert property (@(posedge clk) disable iff (rst)
        inj_valid && inj_ready |=> !inj_valid || (inj_cpu > $past(inj_cpu)));
endmodule

bind intr_dest_resolver idr_checker #(.NUM_CPU(NUM_CPU)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .inj_valid   (inj_valid),
    .inj_ready   (inj_ready),
    .inj_cpu     (inj_cpu),
    .inj_vector  (inj_vector),
    .inj_level   (inj_level),
    .done        (done),
    .unsupported (unsupported)
);

// File: tb/intr_dest_resolver_tb_top.sv
module intr_dest_resolver_tb_top;
    localparam int N     = 8;
    localparam int PW    = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid;
    logic             req_ready;
    logic [7:0]       req_dest;
    logic             req_logical;
    logic [2:0]       req_mode;
    logic [7:0]       req_vec;
    logic             req_level;
    logic [N-1:0]     cpu_present;
    logic [N*8-1:0]   cpu_phys_id;
    logic [N*8-1:0]   cpu_log_id;
    logic [N*PW-1:0]  cpu_prio;
    logic             inj_valid;
    logic             inj_ready;
    logic [IDX_W-1:0] inj_cpu;
    logic [7:0]       inj_vector;
    logic             inj_level;
    logic             done;
    logic             unsupported;

    int checks = 0;
    int fails  = 0;

    logic [7:0] t_phys [N];
    logic [7:0] t_log  [N];
    logic [7:0] t_prio [N];

    always #10 clk = ~clk;

    intr_dest_resolver #(.NUM_CPU(N), .PRIO_W(PW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dest(req_dest), .req_logical(req_logical), .req_mode(req_mode),
        .req_vec(req_vec), .req_level(req_level), .cpu_present(cpu_present),
        .cpu_phys_id(cpu_phys_id), .cpu_log_id(cpu_log_id), .cpu_prio(cpu_prio),
        .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_cpu(inj_cpu),
        .inj_vector(inj_vector), .inj_level(inj_level), .done(done),
        .unsupported(unsupported)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] ref_targets(input logic [7:0] d, input logic lg);
        logic [N-1:0] m = '0;
        if (!lg) begin
            if (d == 8'hFF) m = cpu_present;
            else
                for (int i = N - 1; i >= 0; i--)
                    if (cpu_present[i] && t_phys[i] == d) begin m = '0; m[i] = 1'b1; end
        end else if (d != 0) begin
            for (int i = 0; i < N; i++)
                if (cpu_present[i] && (t_log[i] & d) != 0) m[i] = 1'b1;
        end
        return m;
    endfunction

    task automatic run_case(input string req, input logic [7:0] d, input logic lg,
                            input logic [2:0] mode, input logic [7:0] vec,
                            input logic lvl, input int stall, input logic probe_busy);
        logic [N-1:0] tgt;
        int exp_list[$];
        int got_list[$];
        int done_cyc = -1;
        logic saw_unsup = 1'b0;
        logic exp_unsup;
        int best;
        tgt = ref_targets(d, lg);
        exp_unsup = (mode > 3'd1);
        if (!exp_unsup) begin
            if (mode == 3'd0) begin
                for (int i = 0; i < N; i++) if (tgt[i]) exp_list.push_back(i);
            end else begin
                best = -1;
                for (int i = 0; i < N; i++)
                    if (tgt[i] && (best < 0 || t_prio[i] < t_prio[best])) best = i;
                if (best >= 0) exp_list.push_back(best);
            end
        end
        @(negedge clk);
        req_dest = d; req_logical = lg; req_mode = mode; req_vec = vec;
        req_level = lvl; req_valid = 1'b1; inj_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 40; c++) begin
            inj_ready = (c >= stall);
            #1;
            if (unsupported) saw_unsup = 1'b1;
            if (done) begin done_cyc = c; break; end
            if (probe_busy && inj_valid)
                check(req_ready == 1'b0, {req, " R8 req_ready while busy"}, req_ready, 0);
            if (inj_valid && inj_ready) begin
                got_list.push_back(int'(inj_cpu));
                check(inj_vector == vec && inj_level == lvl, {req, " R5 beat payload"},
                      {inj_vector, 3'b0, inj_level}, {vec, 3'b0, lvl});
            end
            @(negedge clk);
        end
        inj_ready = 1'b0;
        check(got_list.size() == exp_list.size(), {req, " beat count"},
              got_list.size(), exp_list.size());
        for (int k = 0; k < exp_list.size() && k < got_list.size(); k++)
            check(got_list[k] == exp_list[k], {req, " target cpu order"},
                  got_list[k], exp_list[k]);
        check(saw_unsup == exp_unsup, {req, " R7 unsupported flag"}, saw_unsup, exp_unsup);
        check(done_cyc == exp_list.size() + ((exp_list.size() > 0) ? stall : 0),
              {req, " R9 done cycle"}, done_cyc,
              exp_list.size() + ((exp_list.size() > 0) ? stall : 0));
        @(negedge clk);
        check(done == 1'b0, {req, " R9 done single cycle"}, done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_phys = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h22, 8'h66, 8'h77};
        t_log  = '{8'h01, 8'h02, 8'h04, 8'h04, 8'h10, 8'h20, 8'h40, 8'h81};
        t_prio = '{8'd50, 8'd30, 8'd30, 8'd90, 8'd10, 8'd10, 8'd0, 8'd70};
        cpu_present = 8'b1011_1111;
        for (int i = 0; i < N; i++) begin
            cpu_phys_id[i*8 +: 8] = t_phys[i];
            cpu_log_id[i*8 +: 8]  = t_log[i];
            cpu_prio[i*PW +: PW]  = t_prio[i];
        end
        rst = 1'b1; req_valid = 1'b0; inj_ready = 1'b0;
        req_dest = '0; req_logical = 1'b0; req_mode = '0; req_vec = '0; req_level = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        check(req_ready == 1'b1, "R10 req_ready after reset", req_ready, 1);
        check(inj_valid == 1'b0, "R10 inj_valid after reset", inj_valid, 0);
        check(done == 1'b0 && unsupported == 1'b0, "R10 done/unsupported after reset",
              {done, unsupported}, 0);

        run_case("R1 R5 physical broadcast fixed",   8'hFF, 1'b0, 3'd0, 8'h31, 1'b1, 0, 1'b1);
        run_case("R2 physical first match",          8'h22, 1'b0, 3'd0, 8'h40, 1'b0, 0, 1'b0);
        run_case("R2 R4 physical absent cpu",        8'h66, 1'b0, 3'd0, 8'h41, 1'b0, 0, 1'b0);
        run_case("R3 R5 R8 logical fixed stalled",   8'h05, 1'b1, 3'd0, 8'h52, 1'b1, 3, 1'b1);
        run_case("R3 R4 logical zero destination",   8'h00, 1'b1, 3'd0, 8'h53, 1'b0, 0, 1'b0);
        run_case("R6 lowest priority tie to index",  8'hFF, 1'b1, 3'd1, 8'h60, 1'b1, 0, 1'b0);
        run_case("R6 lowest priority equal prio",    8'h06, 1'b1, 3'd1, 8'h61, 1'b0, 2, 1'b1);
        run_case("R6 R2 lowest priority physical",   8'h44, 1'b0, 3'd1, 8'h62, 1'b1, 0, 1'b0);
        for (int m = 2; m < 8; m++)
            run_case("R7 unsupported mode",          8'hFF, 1'b0, 3'(m), 8'h70, 1'b0, 0, 1'b0);
        run_case("R4 R6 lowest priority empty set",  8'h08, 1'b1, 3'd1, 8'h71, 1'b0, 0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule